// File: doc/BRIEF.md
# Multiplicative Segment Identifier Scrambler

This block turns a proto segment identifier into a scrambled segment identifier. It multiplies the proto value by a fixed prime and reduces the product modulo 2^n − 1, with n set by the selected mode. Because the modulus is one less than a power of two, no divider is needed. The product is split at bit n, the two halves are added end-around, and a single carry correction returns the canonical residue. The mapping is one-to-one, which spreads neighbouring proto identifiers across a translation hash table.

Two modes are provided. The wide mode works on 36-bit identifiers with the multiplier 200730139. The narrow mode works on 24-bit identifiers with the multiplier 12538073. The multiplication runs as a shift-and-add over several cycles, taking a fixed number of multiplier bits per cycle. The caller presents a request with a one-cycle `in_valid` while `busy` is low, then waits for the one-cycle `done` strobe. An all-ones proto value lies outside the domain of the mapping and is reported through `err`.

Top module: `sidscr_top`

## Requirements
- R1: With `in_mode` = 0 (wide), `result` equals (in_proto × 200730139) mod (2^36 − 1).
- R2: With `in_mode` = 1 (narrow), only `in_proto[23:0]` is used and `result` equals (in_proto[23:0] × 12538073) mod (2^24 − 1). `result[35:24]` is zero, and `in_proto[35:24]` has no effect on the outcome.
- R3: A result is always the canonical residue. It never equals the all-ones value of the mode width (36 ones in wide mode, 24 ones in the low 24 bits in narrow mode).
- R4: A proto value whose mode-width bits are all ones is reserved. Its completion raises `err` together with `done`, and `result` is zero.
- R5: A request is accepted on a rising edge where `in_valid` = 1 and `busy` = 0. `done` is high for exactly one cycle per accepted request. It is visible right after the 8th rising edge that follows the accepting edge (default parameters: 7 multiply steps plus one output register).
- R6: `busy` is high from the edge after acceptance until `done` is raised. Any `in_valid` seen while `busy` is high is ignored and produces no completion.
- R7: While `rst` (synchronous, active high) is asserted, `done`, `err` and `busy` are low and `result` is zero.
- R8: `err` is low on the completion of any non-reserved proto value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe, taken when `busy` is low |
| in_mode | input | 1 | 0 = wide 36-bit mode, 1 = narrow 24-bit mode |
| in_proto | input | 36 | Proto segment identifier |
| busy | output | 1 | A request is in flight |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Reserved proto value, valid with `done` |
| result | output | 36 | Scrambled identifier, held until the next completion |

## Verification
Random 36-bit proto values in wide mode exercise the full width of the shift-and-add product and both outcomes of the fold carry. Random narrow-mode values carry junk in bits 35:24, so a design that lets those bits into the product, or that picks the wrong lane, gives a different residue. Boundary values separate the edge cases. Zero, one and all-ones minus one probe the low and high ends of the domain. The all-ones value checks the reserved path. Further patterns are a measured latency run and a burst of `in_valid` while busy: these show that the step count is right and that requests arriving during a computation are dropped, not queued.

// File: rtl/sidscr_pkg.sv
package sidscr_pkg;

  typedef enum logic {
    SEG_WIDE   = 1'b0,
    SEG_NARROW = 1'b1
  } seg_mode_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/sidscr_mul.sv
// Shift-and-add multiplier: STEP multiplier bits are consumed per cycle.
module sidscr_mul #(
  parameter int AW   = 36,
  parameter int BW   = 28,
  parameter int STEP = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [AW-1:0]      a,
  input  logic [BW-1:0]      b,
  output logic               busy,
  output logic               prod_valid,
  output logic [AW+BW-1:0]   prod
);
  localparam int PW    = AW + BW;
  localparam int STEPS = sidscr_pkg::ceil_div(BW, STEP);
  localparam int CW    = $clog2(STEPS + 1);

  logic [PW-1:0] acc;
  logic [PW-1:0] mcand;
  logic [BW-1:0] mplier;
  logic [CW-1:0] cnt;
  logic [PW-1:0] term [STEP];
  logic [PW-1:0] pp;

  // One shifted copy of the multiplicand per digit bit.
  for (genvar g = 0; g < STEP; g++) begin : g_term
    assign term[g] = mplier[g] ? (mcand << g) : '0;
  end

  always_comb begin
    pp = '0;
    for (int j = 0; j < STEP; j++) begin
      pp = pp + term[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      prod_valid <= 1'b0;
      acc        <= '0;
      mcand      <= '0;
      mplier     <= '0;
      cnt        <= '0;
    end else begin
      prod_valid <= 1'b0;
      if (start && !busy) begin
        acc    <= '0;
        mcand  <= PW'(a);
        mplier <= b;
        cnt    <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        acc    <= acc + pp;
        mcand  <= mcand << STEP;
        mplier <= mplier >> STEP;
        cnt    <= cnt + 1'b1;
        if (cnt == CW'(STEPS - 1)) begin
          busy       <= 1'b0;
          prod_valid <= 1'b1;
        end
      end
    end
  end

  assign prod = acc;

endmodule

// File: rtl/sidscr_fold_lane.sv
// Residue modulo 2^N-1: end-around add of the halves, then a +1 carry fix.
module sidscr_fold_lane #(
  parameter int PW = 64,
  parameter int N  = 36
) (
  input  logic [PW-1:0] prod,
  output logic [N-1:0]  res
);
  localparam int HW = PW - N;
  localparam int XW = ((HW > N) ? HW : N) + 1;

  logic [XW-1:0] x;
  logic [XW-1:0] corr;

  assign x    = XW'(prod[N-1:0]) + XW'(prod[PW-1:N]);
  assign corr = (x + XW'(1)) >> N;
  assign res  = N'(x + corr);

endmodule

// File: rtl/sidscr_top.sv
module sidscr_top
  import sidscr_pkg::*;
#(
  parameter int             WN         = 36,
  parameter int             NN         = 24,
  parameter int             MULW       = 28,
  parameter int             STEP       = 4,
  parameter logic [MULW-1:0] MUL_WIDE   = MULW'(200730139),
  parameter logic [MULW-1:0] MUL_NARROW = MULW'(12538073)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_mode,
  input  logic [WN-1:0] in_proto,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [WN-1:0] result
);
  localparam int PW  = WN + MULW;
  localparam int LAT = ceil_div(MULW, STEP) + 1;

  seg_mode_e       mode_in;
  seg_mode_e       mode_q;
  logic            accept;
  logic            rsv_in;
  logic            rsv_q;
  logic [WN-1:0]   op_a;
  logic [MULW-1:0] op_b;
  logic            mul_busy;
  logic            prod_valid;
  logic [PW-1:0]   prod;
  logic [WN-1:0]   lane_res [2];

  assign mode_in = seg_mode_e'(in_mode);
  assign accept  = in_valid && !busy;

  always_comb begin
    if (mode_in == SEG_NARROW) begin
      op_a   = WN'(in_proto[NN-1:0]);
      op_b   = MUL_NARROW;
      rsv_in = &in_proto[NN-1:0];
    end else begin
      op_a   = in_proto;
      op_b   = MUL_WIDE;
      rsv_in = &in_proto;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= SEG_WIDE;
      rsv_q  <= 1'b0;
    end else if (accept) begin
      mode_q <= mode_in;
      rsv_q  <= rsv_in;
    end
  end

  sidscr_mul #(
    .AW   (WN),
    .BW   (MULW),
    .STEP (STEP)
  ) u_mul (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .a          (op_a),
    .b          (op_b),
    .busy       (mul_busy),
    .prod_valid (prod_valid),
    .prod       (prod)
  );

  // Lane 0 reduces modulo 2^WN-1, lane 1 modulo 2^NN-1.
  for (genvar l = 0; l < 2; l++) begin : g_lane
    localparam int LN = (l == 0) ? WN : NN;
    logic [LN-1:0] lane_r;
    sidscr_fold_lane #(
      .PW (PW),
      .N  (LN)
    ) u_fold (
      .prod (prod),
      .res  (lane_r)
    );
    assign lane_res[l] = WN'(lane_r);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      err    <= 1'b0;
      result <= '0;
    end else begin
      done <= prod_valid;
      err  <= prod_valid && rsv_q;
      if (prod_valid) begin
        result <= rsv_q ? '0 : lane_res[mode_q == SEG_NARROW];
      end
    end
  end

  assign busy = mul_busy || prod_valid;

endmodule

// File: rtl/sidscr_chk.sv
module sidscr_chk #(
  parameter int WN  = 36,
  parameter int NN  = 24,
  parameter int LAT = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_mode,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [WN-1:0] result
);
  localparam int LCW = $clog2(LAT + 3) + 1;

  logic [LCW-1:0] lat_cnt;
  logic           mode_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cnt <= '0;
      mode_c  <= 1'b0;
    end else if (in_valid && !busy) begin
      lat_cnt <= LCW'(1);
      mode_c  <= in_mode;
    end else if (done) begin
      lat_cnt <= '0;
    end else if (lat_cnt != '0) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == LCW'(LAT + 1)));
  a_r6_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy) |=> busy);
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
  a_r4_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  a_r4_err_zero: assert property (@(posedge clk) disable iff (rst)
    err |-> (result == '0));
  a_r3_wide_canonical: assert property (@(posedge clk) disable iff (rst)
    (done && !mode_c) |-> (result != '1));
  a_r3_narrow_canonical: assert property (@(posedge clk) disable iff (rst)
    (done && mode_c) |-> (result[NN-1:0] != '1));
  a_r2_narrow_upper: assert property (@(posedge clk) disable iff (rst)
    (done && mode_c) |-> (result[WN-1:NN] == '0));

endmodule

bind sidscr_top sidscr_chk #(
  .WN  (WN),
  .NN  (NN),
  .LAT (LAT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_mode  (in_mode),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .result   (result)
);

// File: tb/sidscr_top_tb_top.sv
module sidscr_top_tb_top;
  localparam int WN  = 36;
  localparam int LAT = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_mode = 1'b0;
  logic [WN-1:0] in_proto = '0;
  logic          busy;
  logic          done;
  logic          err;
  logic [WN-1:0] result;

  always #5 clk = ~clk;

  sidscr_top dut_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_mode  (in_mode),
    .in_proto (in_proto),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .result   (result)
  );

  typedef struct {
    logic [WN-1:0] res;
    logic          e;
    string         tag;
  } item_t;

  item_t sbq[$];
  int n_checks = 0;
  int n_fail   = 0;
  int n_issued = 0;
  int n_done   = 0;
  logic prev_done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic item_t model(input logic [WN-1:0] p, input logic narrow,
                                  input string tag);
    item_t it;
    longint unsigned pm, m, md;
    if (narrow) begin
      pm = 64'(p[23:0]);
      m  = 64'd12538073;
      md = (64'd1 << 24) - 64'd1;
    end else begin
      pm = 64'(p);
      m  = 64'd200730139;
      md = (64'd1 << 36) - 64'd1;
    end
    it.tag = tag;
    it.e   = (pm == md);
    it.res = it.e ? '0 : WN'((pm * m) % md);
    return it;
  endfunction

  // Monitor: compare every completion against the scoreboard head.
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        n_done++;
        check(!prev_done, "R5", "done width", 64'(prev_done), 64'd0);
        if (sbq.size() == 0) begin
          check(1'b0, "R6", "unexpected done", 64'd1, 64'd0);
        end else begin
          item_t it;
          it = sbq.pop_front();
          check(result == it.res, it.tag, "result", 64'(result), 64'(it.res));
          check(err == it.e, it.e ? "R4" : "R8", "err", 64'(err), 64'(it.e));
        end
      end
      prev_done = done;
    end
  end

  task automatic issue(input logic [WN-1:0] p, input logic narrow,
                       input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    in_valid = 1'b1;
    in_proto = p;
    in_mode  = narrow;
    sbq.push_back(model(p, narrow, tag));
    n_issued++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((sbq.size() != 0 || busy) && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  // Watchdog: a hung run counts as one failure and still reports.
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R7: reset state, with a request offered during reset.
    in_valid = 1'b1;
    in_proto = 36'h123;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R7", "done in reset", 64'(done), 64'd0);
    check(err == 1'b0, "R7", "err in reset", 64'(err), 64'd0);
    check(busy == 1'b0, "R7", "busy in reset", 64'(busy), 64'd0);
    check(result == '0, "R7", "result in reset", 64'(result), 64'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 boundaries in wide mode.
    issue(36'h0, 1'b0, "R1");
    issue(36'h1, 1'b0, "R1");
    issue(36'h2, 1'b0, "R1");
    issue(36'hFFFFFFFFE, 1'b0, "R3");
    issue(36'h800000000, 1'b0, "R1");
    // R4 reserved values in both modes.
    issue(36'hFFFFFFFFF, 1'b0, "R4");
    issue(36'h000FFFFFF, 1'b1, "R4");
    issue(36'hABCFFFFFF, 1'b1, "R4");
    // R2 boundaries in narrow mode, with junk in the upper bits.
    issue(36'h000000000, 1'b1, "R2");
    issue(36'hFFF000001, 1'b1, "R2");
    issue(36'h000FFFFFE, 1'b1, "R3");
    issue(36'h5A5800000, 1'b1, "R2");
    // R4 negative: wide mode with all-ones only in the low 24 bits.
    issue(36'h000FFFFFF, 1'b0, "R8");

    for (int i = 0; i < 40; i++) begin
      issue(WN'({$urandom(), $urandom()}), 1'b0, "R1");
    end
    for (int i = 0; i < 40; i++) begin
      issue(WN'({$urandom(), $urandom()}), 1'b1, "R2");
    end
    drain();

    // R5: measured latency from the accepting edge.
    begin
      int j;
      @(negedge clk);
      in_valid = 1'b1;
      in_proto = 36'h3C0FFEE01;
      in_mode  = 1'b0;
      sbq.push_back(model(36'h3C0FFEE01, 1'b0, "R5"));
      n_issued++;
      @(negedge clk);
      in_valid = 1'b0;
      check(busy == 1'b1, "R6", "busy after accept", 64'(busy), 64'd1);
      j = 0;
      while (!done && j < 50) begin
        @(negedge clk);
        j++;
      end
      check(j == LAT, "R5", "latency", 64'(j), 64'(LAT));
    end
    drain();

    // R6: requests while busy are dropped.
    issue(36'h0000000AB, 1'b0, "R6");
    in_valid = 1'b1;
    in_proto = 36'h777777777;
    in_mode  = 1'b1;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    drain();
    check(sbq.size() == 0, "R6", "pending items", 64'(sbq.size()), 64'd0);
    check(n_done == n_issued, "R6", "completion count", 64'(n_done), 64'(n_issued));
    check(result == model(36'h0000000AB, 1'b0, "R6").res, "R6", "held result",
          64'(result), 64'(model(36'h0000000AB, 1'b0, "R6").res));

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule